// File: doc/BRIEF.md
# SDRAM Bank/Row/Column Address Mapper with Open-Row Tracking

This block sits in front of an SDRAM command sequencer. It takes a flat word address from a host request and splits it into bank, row and column fields for a four-bank device. It then checks the decoded row against a per-bank record of the row currently open in that bank, and reports whether the access is a row hit or which command sequence the sequencer has to issue first. A static mode input picks one of two field orderings. With the bank field on top, each bank covers one contiguous quarter of the address space. With the bank field between row and column, consecutive column windows rotate through the four banks.

Each result is registered and offered under a valid/ready handshake. The sequencer takes a result once the listed commands have gone out. That acceptance is the confirmation that updates the open-row record. A precharge-all input, which the sequencer pulses for example before refresh, forgets every open row in one cycle. The same happens when the mode input changes. A registered flag tells the power manager whether a self-refresh limited to bank 0 would keep a contiguous low region of memory intact. That holds only with the bank field on top.

Top module: `sdram_row_tracker`

## Requirements
- R1: With `mode_rbc` low, `req_addr` decodes as bank = the two most significant bits, row = the next ROW_W bits, column = the low COL_W bits.
- R2: With `mode_rbc` high, `req_addr` decodes as row = the ROW_W most significant bits, bank = bits [COL_W+1:COL_W], column = the low COL_W bits. Consecutive 2^COL_W-word windows therefore map to banks 0, 1, 2, 3 in turn.
- R3: An access to a bank with no open row reports `rsp_cmd` = 1 (ACTIVE only) and `rsp_hit` = 0.
- R4: An access whose row equals the open row of its bank reports `rsp_cmd` = 0 (no command) and `rsp_hit` = 1.
- R5: An access to a bank whose open row differs from the decoded row reports `rsp_cmd` = 2 (PRECHARGE then ACTIVE) and `rsp_hit` = 0.
- R6: The open-row record of a bank changes only when a result for that bank with `rsp_cmd` ≠ 0 is accepted (`rsp_valid` and `rsp_ready` both high). Afterwards the bank holds the result's row, and no other bank's record changes.
- R7: A result appears on `rsp_valid` in the cycle after the request is accepted. It stays unchanged while `rsp_ready` is low. `req_ready` is low while a result is pending.
- R8: A cycle with `prech_all` high closes every bank, so the next access to any bank reports ACTIVE only.
- R9: A change of `mode_rbc` closes every bank.
- R10: `pasr_ok` is high one cycle after `mode_rbc` is sampled low and low one cycle after it is sampled high. It is high during reset.

Top module ports (widths shown for the default ROW_W = 12, COL_W = 9):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rbc | input | 1 | 0: bank field on top; 1: bank field between row and column |
| prech_all | input | 1 | Close all banks this cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 23 | Flat word address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Commands for the result issued; result taken |
| rsp_bank | output | 2 | Decoded bank |
| rsp_row | output | 12 | Decoded row |
| rsp_col | output | 9 | Decoded column |
| rsp_cmd | output | 2 | 0 none, 1 ACTIVE, 2 PRECHARGE+ACTIVE |
| rsp_hit | output | 1 | Row already open |
| pasr_ok | output | 1 | Bank-0-only self-refresh keeps a contiguous region |

## Verification
The hardest case to reach is a hit on a bank after other banks have opened and reopened rows. Only that case shows that the open-row records really are independent and that a PRECHARGE+ACTIVE result replaces the stored row. The stimulus interleaves accesses over several banks and a small set of rows, holds back `rsp_ready` on some results, and then revisits earlier rows. It repeats this after a precharge-all and after each mode switch. In the interleaved ordering it walks consecutive column windows so the bank rotation produces hits and misses in a known pattern.

// File: rtl/row_tracker_pkg.sv
package row_tracker_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_ACT     = 2'd1,
    CMD_PRE_ACT = 2'd2
  } row_cmd_e;
endpackage

// File: rtl/addr_split.sv
module addr_split #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic              mode_rbc,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  always_comb begin
    col = addr[COL_W-1:0];
    if (mode_rbc) begin
      row  = addr[ADDR_W-1 -: ROW_W];
      bank = addr[COL_W +: BANK_W];
    end else begin
      bank = addr[ADDR_W-1 -: BANK_W];
      row  = addr[COL_W +: ROW_W];
    end
  end
endmodule

// File: rtl/bank_table.sv
module bank_table #(
  parameter int ROW_W  = 12,
  parameter int BANKS  = 4,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_all,
  input  logic                         upd_en,
  input  logic [BANK_W-1:0]            upd_bank,
  input  logic [ROW_W-1:0]             upd_row,
  output logic [BANKS-1:0]             open_vld,
  output logic [BANKS-1:0][ROW_W-1:0]  open_row
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             vld_d;
    logic             row_en;
    logic [ROW_W-1:0] row_q;
    logic             vld_q;

    always_comb begin
      row_en = upd_en && (upd_bank == BANK_W'(b));
      if (clr_all)     vld_d = 1'b0;
      else if (row_en) vld_d = 1'b1;
      else             vld_d = vld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_en) row_q <= upd_row;
    end

    assign open_vld[b] = vld_q;
    assign open_row[b] = row_q;
  end
endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker
  import row_tracker_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  localparam int BANKS  = 4,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rbc,
  input  logic              prech_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BANK_W-1:0] rsp_bank,
  output logic [ROW_W-1:0]  rsp_row,
  output logic [COL_W-1:0]  rsp_col,
  output logic [1:0]        rsp_cmd,
  output logic              rsp_hit,
  output logic              pasr_ok
);
  logic [BANK_W-1:0]            dec_bank;
  logic [ROW_W-1:0]             dec_row;
  logic [COL_W-1:0]             dec_col;
  logic [BANKS-1:0]             open_vld;
  logic [BANKS-1:0][ROW_W-1:0]  open_row;
  logic                         req_fire, rsp_fire, mode_chg;
  logic                         mode_q;
  logic                         vld_q, vld_d;
  logic [BANK_W-1:0]            bank_q;
  logic [ROW_W-1:0]             row_q;
  logic [COL_W-1:0]             col_q;
  row_cmd_e                     cmd_q, cmd_d;
  logic                         hit_q, hit_d;

  addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_split (
    .mode_rbc (mode_rbc),
    .addr     (req_addr),
    .bank     (dec_bank),
    .row      (dec_row),
    .col      (dec_col)
  );

  bank_table #(.ROW_W(ROW_W), .BANKS(BANKS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (prech_all | mode_chg),
    .upd_en   (rsp_fire && (cmd_q != CMD_NONE)),
    .upd_bank (bank_q),
    .upd_row  (row_q),
    .open_vld (open_vld),
    .open_row (open_row)
  );

  assign req_ready = !vld_q;
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = vld_q && rsp_ready;
  assign mode_chg  = mode_rbc ^ mode_q;

  // verdict and handshake next state
  always_comb begin
    if (!open_vld[dec_bank]) begin
      cmd_d = CMD_ACT;
      hit_d = 1'b0;
    end else if (open_row[dec_bank] == dec_row) begin
      cmd_d = CMD_NONE;
      hit_d = 1'b1;
    end else begin
      cmd_d = CMD_PRE_ACT;
      hit_d = 1'b0;
    end
    if (req_fire)      vld_d = 1'b1;
    else if (rsp_fire) vld_d = 1'b0;
    else               vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      mode_q <= mode_rbc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      cmd_q  <= CMD_NONE;
      hit_q  <= 1'b0;
    end else if (req_fire) begin
      bank_q <= dec_bank;
      row_q  <= dec_row;
      col_q  <= dec_col;
      cmd_q  <= cmd_d;
      hit_q  <= hit_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_bank  = bank_q;
  assign rsp_row   = row_q;
  assign rsp_col   = col_q;
  assign rsp_cmd   = cmd_q;
  assign rsp_hit   = hit_q;
  assign pasr_ok   = !mode_q;
endmodule

// File: rtl/row_tracker_chk.sv
module row_tracker_chk #(
  parameter int ROW_W = 12,
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_rbc,
  input logic             prech_all,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_bank,
  input logic [ROW_W-1:0] rsp_row,
  input logic [COL_W-1:0] rsp_col,
  input logic [1:0]       rsp_cmd,
  input logic             rsp_hit,
  input logic             pasr_ok
);
  logic any_open_q;
  logic mode_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_open_q  <= 1'b0;
      mode_seen_q <= 1'b0;
    end else begin
      mode_seen_q <= mode_rbc;
      if (prech_all || (mode_rbc != mode_seen_q))  any_open_q <= 1'b0;
      else if (rsp_valid && rsp_ready && rsp_cmd != 2'd0) any_open_q <= 1'b1;
    end
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bank) && $stable(rsp_row)
      && $stable(rsp_col) && $stable(rsp_cmd) && $stable(rsp_hit));

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // a hit needs a row opened since the last precharge-all or mode change
  assert_hit_after_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> any_open_q);

  assert_hit_nocmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_cmd == 2'd0);

  assert_pasr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pasr_ok == !$past(mode_rbc));
endmodule

bind sdram_row_tracker row_tracker_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_rbc(mode_rbc), .prech_all(prech_all),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_bank(rsp_bank), .rsp_row(rsp_row), .rsp_col(rsp_col),
  .rsp_cmd(rsp_cmd), .rsp_hit(rsp_hit), .pasr_ok(pasr_ok)
);

// File: tb/sim_sdram_row_tracker.sv
module sim_sdram_row_tracker;
  localparam int RW = 12;
  localparam int CW = 9;
  localparam int AW = RW + 2 + CW;

  typedef struct packed {
    logic [1:0]    bank;
    logic [RW-1:0] row;
    logic [CW-1:0] col;
    logic [1:0]    cmd;
    logic          hit;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, mode_rbc, prech_all, req_valid, rsp_ready;
  logic [AW-1:0] req_addr;
  logic req_ready, rsp_valid, rsp_hit, pasr_ok;
  logic [1:0] rsp_bank, rsp_cmd;
  logic [RW-1:0] rsp_row;
  logic [CW-1:0] rsp_col;

  int vectors = 0;
  int miscompares = 0;
  exp_t q[$];
  int hold_q[$];
  logic          m_vld [4];
  logic [RW-1:0] m_row [4];
  int hold_left = -1;

  always #2.5 clk = ~clk;

  sdram_row_tracker #(.ROW_W(RW), .COL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_rbc(mode_rbc), .prech_all(prech_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bank(rsp_bank),
    .rsp_row(rsp_row), .rsp_col(rsp_col), .rsp_cmd(rsp_cmd), .rsp_hit(rsp_hit),
    .pasr_ok(pasr_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] a_brc(input int b, input int r, input int c);
    return {2'(b), RW'(r), CW'(c)};
  endfunction
  function automatic logic [AW-1:0] a_rbc(input int r, input int b, input int c);
    return {RW'(r), 2'(b), CW'(c)};
  endfunction

  // driver: predicts from the requirements, pushes, then drives
  task automatic send(input logic [AW-1:0] a, input int hold);
    exp_t e;
    e.col = a[CW-1:0];
    if (mode_rbc) begin e.row = a[AW-1 -: RW]; e.bank = a[CW +: 2]; end   // R2
    else          begin e.bank = a[AW-1 -: 2]; e.row = a[CW +: RW]; end   // R1
    if (!m_vld[e.bank])               begin e.cmd = 2'd1; e.hit = 1'b0; end // R3
    else if (m_row[e.bank] == e.row)  begin e.cmd = 2'd0; e.hit = 1'b1; end // R4
    else                              begin e.cmd = 2'd2; e.hit = 1'b0; end // R5
    if (e.cmd != 2'd0) begin m_vld[e.bank] = 1'b1; m_row[e.bank] = e.row; end // R6
    q.push_back(e);
    hold_q.push_back(hold);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 rsp_valid one cycle after accept", 32'(rsp_valid), 32'd1);
    check("R7 req_ready low while pending", 32'(req_ready), 32'd0);
  endtask

  task automatic wait_idle();
    while (q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  task automatic close_all();
    wait_idle();
    prech_all = 1'b1;
    @(negedge clk);
    prech_all = 1'b0;
    for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;  // R8
  endtask

  task automatic set_mode(input logic m);
    wait_idle();
    mode_rbc = m;
    @(negedge clk);
    for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;  // R9
    check("R10 pasr_ok follows mode", 32'(pasr_ok), 32'(!m));
    @(negedge clk);
  endtask

  // monitor: pops and compares on each accepted result
  initial begin
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (hold_left < 0) hold_left = (hold_q.size() != 0) ? hold_q[0] : 0;
        if (hold_left > 0) begin
          rsp_ready = 1'b0;
          hold_left--;
        end else begin
          rsp_ready = 1'b1;
          if (q.size() == 0) begin
            check("R7 unexpected result", 32'd1, 32'd0);
          end else begin
            check("R1/R2 bank", 32'(rsp_bank), 32'(q[0].bank));
            check("R1/R2 row", 32'(rsp_row), 32'(q[0].row));
            check("R1/R2 col", 32'(rsp_col), 32'(q[0].col));
            check("R3/R4/R5 cmd", 32'(rsp_cmd), 32'(q[0].cmd));
            check("R4 hit", 32'(rsp_hit), 32'(q[0].hit));
            void'(q.pop_front());
            void'(hold_q.pop_front());
          end
          hold_left = -1;
        end
      end else begin
        rsp_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; mode_rbc = 1'b0; prech_all = 1'b0; req_valid = 1'b0; req_addr = '0;
    for (int i = 0; i < 4; i++) begin m_vld[i] = 1'b0; m_row[i] = '0; end
    repeat (3) @(negedge clk);
    check("R7 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R7 reset req_ready", 32'(req_ready), 32'd1);
    check("R10 reset pasr_ok", 32'(pasr_ok), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // bank on top (R1)
    send(a_brc(0, 5, 10), 0);    // R3
    send(a_brc(0, 5, 300), 0);   // R4
    send(a_brc(1, 5, 0), 2);     // R3, held result
    send(a_brc(0, 7, 1), 0);     // R5
    send(a_brc(1, 5, 3), 3);     // R6 bank1 untouched by bank0
    send(a_brc(3, 4095, 511), 0);
    send(a_brc(0, 7, 2), 0);     // R6 new row kept
    close_all();                 // R8
    send(a_brc(0, 7, 2), 0);
    send(a_brc(1, 5, 2), 0);

    // interleaved (R2, R9)
    set_mode(1'b1);
    send(a_rbc(7, 2, 4), 0);
    send(a_rbc(7, 2, 5), 0);
    for (int w = 0; w < 8; w++) send(AW'(w) << CW, w % 2);  // window rotation R2
    send(a_rbc(9, 1, 0), 0);
    close_all();
    send(a_rbc(9, 1, 0), 0);

    // mixed traffic over few rows in both modes
    lf = 16'hACE1;
    for (int k = 0; k < 120; k++) begin
      if (k == 60) set_mode(1'b0);
      if (k == 90) close_all();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (mode_rbc) send(a_rbc(lf[1:0], lf[3:2], lf[12:4]), lf[15:14]);
      else          send(a_brc(lf[3:2], lf[1:0], lf[12:4]), lf[15:14]);
    end
    set_mode(1'b1);
    set_mode(1'b0);
    send(a_brc(2, 3, 3), 0);     // R9 closed by mode toggles
    wait_idle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule